// File: doc/BRIEF.md
# Message Buffer DMA Handshake Logic

This block sits between a message buffer held in shared word-addressed memory and a 32-bit host register port. Every message object in one buffer has the same configured size in 32-bit words. Receive and transmit objects share that layout. On the receive side the block tracks how many complete messages the buffer holds. It counts the words the host or a DMA engine reads from the head message, and it can free that slot by itself once the last word has been read. On the transmit side it counts the words written into a free slot, and it can raise the transmit request for that slot by itself once the last word has been written.

A single request line serves two purposes. With DMA enabled it asks a DMA engine to move one complete received message. With DMA disabled it works as an interrupt that means either "a received message can be read" or "the transmit buffer can take another message". The automatic acknowledge and automatic transmit request work with or without DMA. The host can also acknowledge a message or request transmission by an explicit strobe. Reads that find nothing to read, and writes into a full transmit buffer, are dropped. Each kind sets its own sticky error flag.

Top module: `mbh_dma_handshake`

## Requirements
- R1: While `rst` is high, and on the first clock edge that samples it, every output goes to zero. This clears both sticky error flags.
- R2: Each accepted receive read advances `rx_word_idx` by one. The read that sees index `L-1` wraps it to 0, where L is `cfg_msg_words`. A value of 0 or 1 means one-word messages, and a value above MAX_WORDS is treated as MAX_WORDS.
- R3: With `cfg_auto_ack` set, an accepted read of word `L-1` makes `rx_ack` high for exactly the following cycle and frees one receive slot. With `cfg_auto_ack` clear, no pulse follows.
- R4: `rx_ack_wr` while at least one received message is held pulses `rx_ack` in the next cycle, frees the head slot and returns `rx_word_idx` to 0. With no message held it is ignored.
- R5: With `cfg_dma_en` set, `dma_req` is high exactly when, after the previous edge, a held message exists whose last word has not yet been read. It drops in the cycle after the last word is read and comes back only if another complete message is waiting.
- R6: With `cfg_dma_en` clear, `dma_req` is high when the condition of R5 holds or when the transmit buffer holds fewer than DEPTH requested messages.
- R7: Each accepted transmit write advances `tx_word_idx` and wraps it after word `L-1`, under the same length rule as R2. With `cfg_auto_txreq` set, the write of word `L-1` pulses `tx_req` for one cycle and occupies one transmit slot.
- R8: `tx_req_wr` while fewer than DEPTH transmit slots are occupied pulses `tx_req` in the next cycle, occupies a slot and returns `tx_word_idx` to 0. When all slots are occupied it is ignored.
- R9: A receive read is accepted only when a message is held and the head message has not already been read to its end. A read that is not accepted leaves `rx_word_idx` unchanged and sets `err_rd_empty`, which stays set until reset.
- R10: A transmit write while DEPTH slots are occupied leaves `tx_word_idx` unchanged and sets `err_wr_full`, which stays set until reset.
- R11: `rx_msg_stored` adds a held message unless DEPTH are already held. `tx_msg_sent` releases an occupied transmit slot when one is occupied. Both counts are observable through `dma_req`.
- R12: The automatic acknowledge of R3 and the automatic transmit request of R7 behave identically whatever the value of `cfg_dma_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_msg_words | input | $clog2(MAX_WORDS+1) | Message length in 32-bit words |
| cfg_dma_en | input | 1 | 1: `dma_req` is a receive DMA request; 0: it is an interrupt |
| cfg_auto_ack | input | 1 | Acknowledge automatically after the last word is read |
| cfg_auto_txreq | input | 1 | Request transmission automatically after the last word is written |
| rx_msg_stored | input | 1 | The receive handler has stored one complete message |
| rx_rd | input | 1 | Host or DMA reads one word of the head receive message |
| rx_ack_wr | input | 1 | Host acknowledges the head receive message explicitly |
| tx_wr | input | 1 | Host or DMA writes one word of the current transmit slot |
| tx_req_wr | input | 1 | Host requests transmission of the current slot explicitly |
| tx_msg_sent | input | 1 | The CAN engine has finished with one transmit slot |
| rx_word_idx | output | $clog2(MAX_WORDS) | Word offset of the next receive read |
| tx_word_idx | output | $clog2(MAX_WORDS) | Word offset of the next transmit write |
| rx_ack | output | 1 | One-cycle pulse: head receive slot freed |
| tx_req | output | 1 | One-cycle pulse: transmit slot handed to the engine |
| dma_req | output | 1 | DMA request or interrupt (see R5 and R6) |
| err_rd_empty | output | 1 | Sticky flag: a receive read was refused |
| err_wr_full | output | 1 | Sticky flag: a transmit write was refused |

## Verification
The bound checker watches, on every cycle, the properties that follow a single event. It checks that a last-word read or write under the automatic option produces its pulse, and that the request drops when the only message has been read to its end. It checks that refused accesses leave the word index alone and raise a flag that never falls back, that the index steps by one on accepted mid-message reads, and that reset clears every output. What only the bench's scenarios can show is the agreement of the whole state over long runs. That covers held-message and occupied-slot counts under stores, sends and acknowledges arriving in the same cycle, saturation at DEPTH, the interrupt meaning of `dma_req`, and message lengths of zero, one and several words.

// File: rtl/mbh_pkg.sv
package mbh_pkg;

    // Where a word counter is told to go next.
    typedef enum logic [1:0] {
        STEP_HOLD  = 2'd0,
        STEP_NEXT  = 2'd1,
        STEP_WRAP  = 2'd2,
        STEP_CLEAR = 2'd3
    } step_e;

    // Decoded per-direction control for one cycle.
    typedef struct packed {
        logic accept;     // word access taken
        logic last;       // current word is the final one of the message
        logic fire_auto;  // automatic completion on the last word
        logic fire_host;  // explicit completion strobe accepted
    } dir_ctl_t;

    // A length of 0 counts as 1; a length above the maximum counts as the maximum.
    function automatic logic word_is_last(input int unsigned idx,
                                          input int unsigned len,
                                          input int unsigned max_words);
        return (idx + 1 >= len) || (idx + 1 >= max_words);
    endfunction

    function automatic step_e pick_step(input logic clear, input logic take, input logic last);
        if (clear)     return STEP_CLEAR;
        else if (take) return last ? STEP_WRAP : STEP_NEXT;
        else           return STEP_HOLD;
    endfunction

endpackage

// File: rtl/mbh_word_ctr.sv
module mbh_word_ctr
    import mbh_pkg::*;
#(
    parameter int MAX_WORDS = 16,
    parameter int IDX_W     = $clog2(MAX_WORDS),
    parameter int LEN_W     = $clog2(MAX_WORDS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    input  logic             clear,
    input  logic [LEN_W-1:0] len,
    output logic [IDX_W-1:0] idx,
    output logic             last
);

    step_e step;

    assign last = word_is_last(32'(idx), 32'(len), MAX_WORDS);
    assign step = pick_step(clear, take, last);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx <= '0;
        end else begin
            case (step)
                STEP_NEXT:  idx <= idx + IDX_W'(1);
                STEP_WRAP,
                STEP_CLEAR: idx <= '0;
                default:    idx <= idx;
            endcase
        end
    end

endmodule

// File: rtl/mbh_level_ctr.sv
module mbh_level_ctr #(
    parameter int DEPTH = 4,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    input  logic             dec,
    output logic [LVL_W-1:0] level,
    output logic [LVL_W-1:0] level_nx,
    output logic             full,
    output logic             empty
);

    localparam logic [LVL_W-1:0] TOP = LVL_W'(DEPTH);

    assign full     = (level == TOP);
    assign empty    = (level == '0);
    // Callers gate inc with !full and dec with !empty.
    assign level_nx = level + LVL_W'(inc) - LVL_W'(dec);

    always_ff @(posedge clk) begin
        if (rst) level <= '0;
        else     level <= level_nx;
    end

endmodule

// File: rtl/mbh_dma_handshake.sv
module mbh_dma_handshake
    import mbh_pkg::*;
#(
    parameter int DEPTH     = 4,
    parameter int MAX_WORDS = 16,
    parameter int IDX_W     = $clog2(MAX_WORDS),
    parameter int LEN_W     = $clog2(MAX_WORDS + 1),
    parameter int LVL_W     = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LEN_W-1:0] cfg_msg_words,
    input  logic             cfg_dma_en,
    input  logic             cfg_auto_ack,
    input  logic             cfg_auto_txreq,
    input  logic             rx_msg_stored,
    input  logic             rx_rd,
    input  logic             rx_ack_wr,
    input  logic             tx_wr,
    input  logic             tx_req_wr,
    input  logic             tx_msg_sent,
    output logic [IDX_W-1:0] rx_word_idx,
    output logic [IDX_W-1:0] tx_word_idx,
    output logic             rx_ack,
    output logic             tx_req,
    output logic             dma_req,
    output logic             err_rd_empty,
    output logic             err_wr_full
);

    localparam logic [LVL_W-1:0] TOP = LVL_W'(DEPTH);

    dir_ctl_t         rx_c, tx_c;
    logic             rx_last, tx_last;
    logic             rx_full, rx_empty, tx_full, tx_empty;
    logic [LVL_W-1:0] rx_lvl, rx_lvl_nx, tx_lvl, tx_lvl_nx;
    logic             rx_drained, rx_drained_nx;
    logic             rd_ok, tx_wr_ok;
    logic             rx_free, tx_take;
    logic             dma_nx;

    // ---------------- receive side ----------------
    assign rd_ok = rx_rd && !rx_empty && !rx_drained;

    always_comb begin
        rx_c.accept    = rd_ok;
        rx_c.last      = rx_last;
        rx_c.fire_auto = rd_ok && rx_last && cfg_auto_ack;
        rx_c.fire_host = rx_ack_wr && !rx_empty;
    end

    assign rx_free = rx_c.fire_auto || rx_c.fire_host;

    // Head fully read but not yet freed: further reads are refused.
    always_comb begin
        if (rx_free)
            rx_drained_nx = 1'b0;
        else if (rx_c.accept && rx_c.last)
            rx_drained_nx = 1'b1;
        else
            rx_drained_nx = rx_drained;
    end

    mbh_word_ctr #(.MAX_WORDS(MAX_WORDS), .IDX_W(IDX_W), .LEN_W(LEN_W)) u_rx_words (
        .clk   (clk),
        .rst   (rst),
        .take  (rx_c.accept),
        .clear (rx_c.fire_host),
        .len   (cfg_msg_words),
        .idx   (rx_word_idx),
        .last  (rx_last)
    );

    mbh_level_ctr #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_rx_level (
        .clk      (clk),
        .rst      (rst),
        .inc      (rx_msg_stored && !rx_full),
        .dec      (rx_free),
        .level    (rx_lvl),
        .level_nx (rx_lvl_nx),
        .full     (rx_full),
        .empty    (rx_empty)
    );

    // ---------------- transmit side ----------------
    assign tx_wr_ok = tx_wr && !tx_full;

    always_comb begin
        tx_c.accept    = tx_wr_ok;
        tx_c.last      = tx_last;
        tx_c.fire_auto = tx_wr_ok && tx_last && cfg_auto_txreq;
        tx_c.fire_host = tx_req_wr && !tx_full;
    end

    assign tx_take = tx_c.fire_auto || tx_c.fire_host;

    mbh_word_ctr #(.MAX_WORDS(MAX_WORDS), .IDX_W(IDX_W), .LEN_W(LEN_W)) u_tx_words (
        .clk   (clk),
        .rst   (rst),
        .take  (tx_c.accept),
        .clear (tx_c.fire_host),
        .len   (cfg_msg_words),
        .idx   (tx_word_idx),
        .last  (tx_last)
    );

    mbh_level_ctr #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_tx_level (
        .clk      (clk),
        .rst      (rst),
        .inc      (tx_take),
        .dec      (tx_msg_sent && !tx_empty),
        .level    (tx_lvl),
        .level_nx (tx_lvl_nx),
        .full     (tx_full),
        .empty    (tx_empty)
    );

    // ---------------- request line and flags ----------------
    always_comb begin
        dma_nx = (rx_lvl_nx != '0) && !rx_drained_nx;
        if (!cfg_dma_en && (tx_lvl_nx != TOP))
            dma_nx = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_drained   <= 1'b0;
            rx_ack       <= 1'b0;
            tx_req       <= 1'b0;
            dma_req      <= 1'b0;
            err_rd_empty <= 1'b0;
            err_wr_full  <= 1'b0;
        end else begin
            rx_drained   <= rx_drained_nx;
            rx_ack       <= rx_free;
            tx_req       <= tx_take;
            dma_req      <= dma_nx;
            err_rd_empty <= err_rd_empty || (rx_rd && !rd_ok);
            err_wr_full  <= err_wr_full || (tx_wr && tx_full);
        end
    end

endmodule

// File: rtl/mbh_dma_handshake_chk.sv
module mbh_dma_handshake_chk #(
    parameter int IDX_W = 4,
    parameter int LVL_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_dma_en,
    input logic             cfg_auto_ack,
    input logic             cfg_auto_txreq,
    input logic             rx_msg_stored,
    input logic             rx_rd,
    input logic             rx_ack_wr,
    input logic             tx_wr,
    input logic             tx_req_wr,
    input logic             rd_ok,
    input logic             rx_last,
    input logic             tx_wr_ok,
    input logic             tx_last,
    input logic             tx_full,
    input logic [LVL_W-1:0] rx_lvl,
    input logic [IDX_W-1:0] rx_word_idx,
    input logic [IDX_W-1:0] tx_word_idx,
    input logic             rx_ack,
    input logic             tx_req,
    input logic             dma_req,
    input logic             err_rd_empty,
    input logic             err_wr_full
);

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!dma_req && !rx_ack && !tx_req && !err_rd_empty && !err_wr_full
                 && rx_word_idx == '0 && tx_word_idx == '0));

    a_r2_rx_index_step: assert property (@(posedge clk) disable iff (rst)
        (rd_ok && !rx_last && !rx_ack_wr) |=> rx_word_idx == IDX_W'($past(rx_word_idx) + 1'b1));

    a_r3_auto_ack_pulse: assert property (@(posedge clk) disable iff (rst)
        (rd_ok && rx_last && cfg_auto_ack) |=> rx_ack);

    a_r5_request_drops: assert property (@(posedge clk) disable iff (rst)
        (cfg_dma_en && rd_ok && rx_last && rx_lvl == LVL_W'(1) && !rx_msg_stored) |=> !dma_req);

    a_r7_auto_txreq_pulse: assert property (@(posedge clk) disable iff (rst)
        (tx_wr_ok && tx_last && cfg_auto_txreq) |=> tx_req);

    a_r9_refused_read: assert property (@(posedge clk) disable iff (rst)
        (rx_rd && !rd_ok && !rx_ack_wr) |=> (err_rd_empty && $stable(rx_word_idx)));

    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        err_rd_empty |=> err_rd_empty);

    a_r10_refused_write: assert property (@(posedge clk) disable iff (rst)
        (tx_wr && tx_full) |=> (err_wr_full && $stable(tx_word_idx)));

    a_r10_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        err_wr_full |=> err_wr_full);

endmodule

bind mbh_dma_handshake mbh_dma_handshake_chk #(.IDX_W(IDX_W), .LVL_W(LVL_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .cfg_dma_en     (cfg_dma_en),
    .cfg_auto_ack   (cfg_auto_ack),
    .cfg_auto_txreq (cfg_auto_txreq),
    .rx_msg_stored  (rx_msg_stored),
    .rx_rd          (rx_rd),
    .rx_ack_wr      (rx_ack_wr),
    .tx_wr          (tx_wr),
    .tx_req_wr      (tx_req_wr),
    .rd_ok          (rd_ok),
    .rx_last        (rx_last),
    .tx_wr_ok       (tx_wr_ok),
    .tx_last        (tx_last),
    .tx_full        (tx_full),
    .rx_lvl         (rx_lvl),
    .rx_word_idx    (rx_word_idx),
    .tx_word_idx    (tx_word_idx),
    .rx_ack         (rx_ack),
    .tx_req         (tx_req),
    .dma_req        (dma_req),
    .err_rd_empty   (err_rd_empty),
    .err_wr_full    (err_wr_full)
);

// File: tb/test_mbh_dma_handshake.sv
module test_mbh_dma_handshake;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 4;
    localparam int MAX_WORDS  = 16;
    localparam int IDX_W      = $clog2(MAX_WORDS);
    localparam int LEN_W      = $clog2(MAX_WORDS + 1);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [LEN_W-1:0] cfg_msg_words = '0;
    logic             cfg_dma_en = 1'b0, cfg_auto_ack = 1'b0, cfg_auto_txreq = 1'b0;
    logic             rx_msg_stored = 1'b0, rx_rd = 1'b0, rx_ack_wr = 1'b0;
    logic             tx_wr = 1'b0, tx_req_wr = 1'b0, tx_msg_sent = 1'b0;
    logic [IDX_W-1:0] rx_word_idx, tx_word_idx;
    logic             rx_ack, tx_req, dma_req, err_rd_empty, err_wr_full;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // bench model state
    int m_rl, m_dr, m_ri, m_tl, m_ti, m_erd, m_ewr;
    int e_ack, e_req, e_dma;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mbh_dma_handshake #(.DEPTH(DEPTH), .MAX_WORDS(MAX_WORDS)) i_mbh_dma_handshake (
        .clk(clk), .rst(rst), .cfg_msg_words(cfg_msg_words), .cfg_dma_en(cfg_dma_en),
        .cfg_auto_ack(cfg_auto_ack), .cfg_auto_txreq(cfg_auto_txreq),
        .rx_msg_stored(rx_msg_stored), .rx_rd(rx_rd), .rx_ack_wr(rx_ack_wr),
        .tx_wr(tx_wr), .tx_req_wr(tx_req_wr), .tx_msg_sent(tx_msg_sent),
        .rx_word_idx(rx_word_idx), .tx_word_idx(tx_word_idx), .rx_ack(rx_ack),
        .tx_req(tx_req), .dma_req(dma_req), .err_rd_empty(err_rd_empty),
        .err_wr_full(err_wr_full)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int eff_len(input int len);
        if (len == 0) return 1;
        if (len > MAX_WORDS) return MAX_WORDS;
        return len;
    endfunction

    task automatic idle();
        rx_msg_stored = 0; rx_rd = 0; rx_ack_wr = 0;
        tx_wr = 0; tx_req_wr = 0; tx_msg_sent = 0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        idle();
        repeat (2) @(posedge clk);
        #1;
        chk("R1 reset dma_req", int'(dma_req), 0);
        chk("R1 reset rx_ack/tx_req", int'(rx_ack) + int'(tx_req), 0);
        chk("R1 reset flags", int'(err_rd_empty) + int'(err_wr_full), 0);
        chk("R1 reset indices", int'(rx_word_idx) + int'(tx_word_idx), 0);
        m_rl = 0; m_dr = 0; m_ri = 0; m_tl = 0; m_ti = 0; m_erd = 0; m_ewr = 0;
        rst = 1'b0;
    endtask

    // One clock: predict from the requirements, advance, compare.
    task automatic cycle();
        int L, rdok, lr, aack, mack, st, wok, lt, areq, mreq, dec;
        int n_rl, n_dr, n_ri, n_tl, n_ti;
        string t_ack, t_req, t_dma;
        L    = eff_len(int'(cfg_msg_words));
        rdok = (rx_rd && m_rl != 0 && m_dr == 0) ? 1 : 0;
        lr   = (m_ri + 1 >= L) ? 1 : 0;
        aack = (rdok && lr && cfg_auto_ack) ? 1 : 0;
        mack = (rx_ack_wr && m_rl != 0) ? 1 : 0;
        st   = (rx_msg_stored && m_rl < DEPTH) ? 1 : 0;
        n_rl = m_rl + st - ((aack || mack) ? 1 : 0);
        n_dr = (aack || mack) ? 0 : ((rdok && lr) ? 1 : m_dr);
        n_ri = mack ? 0 : (rdok ? (lr ? 0 : m_ri + 1) : m_ri);
        wok  = (tx_wr && m_tl < DEPTH) ? 1 : 0;
        lt   = (m_ti + 1 >= L) ? 1 : 0;
        areq = (wok && lt && cfg_auto_txreq) ? 1 : 0;
        mreq = (tx_req_wr && m_tl < DEPTH) ? 1 : 0;
        dec  = (tx_msg_sent && m_tl > 0) ? 1 : 0;
        n_tl = m_tl + ((areq || mreq) ? 1 : 0) - dec;
        n_ti = mreq ? 0 : (wok ? (lt ? 0 : m_ti + 1) : m_ti);
        if (rx_rd && !rdok) m_erd = 1;
        if (tx_wr && m_tl >= DEPTH) m_ewr = 1;
        e_ack = (aack || mack) ? 1 : 0;
        e_req = (areq || mreq) ? 1 : 0;
        e_dma = ((n_rl != 0 && n_dr == 0) || (!cfg_dma_en && n_tl < DEPTH)) ? 1 : 0;
        t_ack = mack ? "R4 host acknowledge" : (!cfg_dma_en && aack) ? "R12 auto-ack without DMA" : "R3 auto-ack";
        t_req = mreq ? "R8 host transmit request" : (!cfg_dma_en && areq) ? "R12 auto-txreq without DMA" : "R7 auto transmit request";
        t_dma = (st || dec) ? "R11 level tracking" : (cfg_dma_en ? "R5 DMA request" : "R6 interrupt mode");
        @(posedge clk);
        #1;
        m_rl = n_rl; m_dr = n_dr; m_ri = n_ri; m_tl = n_tl; m_ti = n_ti;
        chk("R2 rx word index", int'(rx_word_idx), m_ri);
        chk("R7 tx word index", int'(tx_word_idx), m_ti);
        chk(t_ack, int'(rx_ack), e_ack);
        chk(t_req, int'(tx_req), e_req);
        chk(t_dma, int'(dma_req), e_dma);
        chk("R9 read refusal flag", int'(err_rd_empty), m_erd);
        chk("R10 write refusal flag", int'(err_wr_full), m_ewr);
        idle();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset();

        // Directed: DMA mode, two-word messages, auto acknowledge.
        cfg_dma_en = 1; cfg_auto_ack = 1; cfg_msg_words = LEN_W'(2);
        rx_msg_stored = 1; cycle();
        chk("R5 request after one stored message", int'(dma_req), 1);
        rx_rd = 1; cycle();
        chk("R5 request held mid-message", int'(dma_req), 1);
        rx_rd = 1; cycle();
        chk("R5 request drops after last word", int'(dma_req), 0);
        chk("R3 auto-ack pulse after last word", int'(rx_ack), 1);
        cycle();
        chk("R3 pulse lasts one cycle", int'(rx_ack), 0);

        // Directed: read with nothing held.
        rx_rd = 1; cycle();
        chk("R9 refused read sets flag", int'(err_rd_empty), 1);
        chk("R9 refused read keeps index", int'(rx_word_idx), 0);

        // Directed: fill transmit slots with one-word messages (length 0).
        cfg_msg_words = '0; cfg_auto_txreq = 1;
        for (int i = 0; i < DEPTH; i++) begin tx_wr = 1; cycle(); end
        tx_wr = 1; cycle();
        chk("R10 write to full buffer sets flag", int'(err_wr_full), 1);
        tx_req_wr = 1; cycle();
        chk("R8 host request ignored when full", int'(tx_req), 0);
        cfg_dma_en = 0; tx_msg_sent = 1; cycle();
        chk("R6 interrupt on free transmit slot", int'(dma_req), 1);

        // Directed: no auto-ack, head drained then host acknowledge.
        do_reset();
        cfg_dma_en = 1; cfg_auto_ack = 0; cfg_msg_words = LEN_W'(1);
        rx_msg_stored = 1; cycle();
        rx_msg_stored = 1; cycle();
        rx_rd = 1; cycle();
        chk("R5 drained head removes request", int'(dma_req), 0);
        rx_rd = 1; cycle();
        chk("R9 read of drained head refused", int'(err_rd_empty), 1);
        rx_ack_wr = 1; cycle();
        chk("R4 host acknowledge pulse", int'(rx_ack), 1);
        chk("R5 request back for waiting message", int'(dma_req), 1);

        // Random phase.
        for (int blk = 0; blk < 40; blk++) begin
            if (blk % 10 == 0) do_reset();
            cfg_msg_words  = LEN_W'($urandom_range(0, 6));
            cfg_dma_en     = 1'($urandom_range(0, 1));
            cfg_auto_ack   = 1'($urandom_range(0, 1));
            cfg_auto_txreq = 1'($urandom_range(0, 1));
            for (int c = 0; c < 150; c++) begin
                rx_msg_stored = ($urandom_range(0, 99) < 20);
                rx_rd         = ($urandom_range(0, 99) < 50);
                rx_ack_wr     = ($urandom_range(0, 99) < 6);
                tx_wr         = ($urandom_range(0, 99) < 45);
                tx_req_wr     = ($urandom_range(0, 99) < 6);
                tx_msg_sent   = ($urandom_range(0, 99) < 15);
                cycle();
            end
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule